// File: doc/BRIEF.md
# Sparse-Coefficient Shift-Add FIR Filter

A fixed-coefficient FIR filter that contains no general multiplier. Every coefficient is an 8-bit non-negative value written as a short list of signed power-of-two terms. Each tap product is therefore a sum or difference of shifted copies of the stored sample. Terms that are absent cost no logic. A tap costs at most two adders in unsigned mode, where up to three set bits are allowed. It costs a single adder/subtractor in signed-digit mode, where up to two digits weighted +1 or -1 are allowed.

Samples arrive as a signed stream qualified by a strobe and shift through a delay line only when the strobe is high. Each tap product is registered. A binary adder tree then sums the products, with a register after every level. The result leaves at full precision together with a delayed copy of the input strobe. Coefficients are fixed by parameter, and a coefficient that breaks the digit limit of the chosen mode stops elaboration.

Top module: `shiftadd_fir`

## Requirements
- R1: A synchronous active-high `rst` clears the delay line, the product registers and the tree registers. On the edge after any cycle with `rst` high, `out_valid` is 0 and `out_data` is 0. A sample offered with `in_valid` high while `rst` is high is not accepted.
- R2: The delay line advances only on a clock edge where `in_valid` is high. The newest accepted sample becomes tap 0 and each older sample moves one tap further. When `in_valid` is low, `in_data` has no effect on any later output.
- R3: Define LAT = 2 + ceil(log2(NTAPS)). A sample accepted at a clock edge produces exactly one `out_valid` pulse, and that pulse is visible after the LAT-th rising edge, counting the accepting edge as the first. `out_valid` is never high otherwise.
- R4: With `out_valid` high, `out_data` equals sum over k of c_k * x_k as a two's complement value of IN_W + 8 + ceil(log2(NTAPS)) bits. Here x_0 is the newest accepted sample, x_k the k-th older one (0 before any sample), and c_k the value of tap k. No input pattern overflows this width.
- R5: `COEF_CODES` holds 3 term slots of 5 bits per tap. Slot j of tap k occupies bits [15k+5j +: 5]. Bit 4 enables the slot, bit 3 makes it negative, and bits 2:0 give the shift s. The tap value is the sum of the enabled terms, each +2^s or -2^s.
- R6: Unsigned mode (`SIGNED_DIGITS`=0) accepts a tap only if it has no negative term and no two enabled terms share a shift. This allows at most three set bits, a largest value of 224 (bits 7, 6, 5), and every value from 1 to 14 as well as 16 and 17.
- R7: Signed-digit mode (`SIGNED_DIGITS`=1) accepts a tap only if it has at most two enabled terms, no shared shift, and a value in 0..255. Examples are 7 = 8-1, 9 = 8+1, 24 = 16+8 and 56 = 64-8.
- R8: A tap code that the rules of R6 or R7 reject for the chosen mode raises an error during elaboration.
- R9: A tap count that is not a power of two is padded with zero leaves in the tree. The latency of R3 uses the rounded-up level count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_data` for acceptance |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Marks a filtered result |
| out_data | output | IN_W+8+ceil(log2(NTAPS)) | Signed full-precision filter output |

## Verification
The situation hardest to reach from the ports is a sum at its extreme. That needs every tap filled with the most negative or most positive sample while the largest coefficients line up, and it has to happen while the tree still holds results from earlier samples. The stimulus therefore streams long runs of -2048 and +2047 through both a power-of-two and a padded five-tap instance. It also inserts idle gaps carrying random data and a reset in the middle of a random stream, so that partial sums in flight are either kept or dropped. The digit-limit rules are checked separately through the legality function, using codes that the filter instances cannot be built with.

// File: rtl/shiftadd_fir_pkg.sv
package shiftadd_fir_pkg;

  localparam int SHIFT_W   = 3;
  localparam int TERM_W    = SHIFT_W + 2;
  localparam int SLOTS     = 3;
  localparam int CODE_W    = TERM_W * SLOTS;
  localparam int COEF_BITS = 8;
  localparam int EN_BIT    = TERM_W - 1;
  localparam int NEG_BIT   = TERM_W - 2;
  localparam int UNSIGNED_MAX_DIGITS = 3;
  localparam int SIGNED_MAX_DIGITS   = 2;

  // Number of registered levels in a binary tree with n leaves.
  function automatic int tree_levels(input int n);
    int l;
    l = 0;
    while ((1 << l) < n) l++;
    return l;
  endfunction

  function automatic logic [TERM_W-1:0] slot_of(input logic [CODE_W-1:0] code, input int j);
    return code[j*TERM_W +: TERM_W];
  endfunction

  function automatic int term_weight(input logic [TERM_W-1:0] t);
    int mag;
    if (!t[EN_BIT]) return 0;
    mag = 1 << int'(t[SHIFT_W-1:0]);
    return t[NEG_BIT] ? -mag : mag;
  endfunction

  function automatic int code_value(input logic [CODE_W-1:0] code);
    int v;
    v = 0;
    for (int j = 0; j < SLOTS; j++) v += term_weight(slot_of(code, j));
    return v;
  endfunction

  function automatic int code_digits(input logic [CODE_W-1:0] code);
    int n;
    n = 0;
    for (int j = 0; j < SLOTS; j++) if (slot_of(code, j)[EN_BIT]) n++;
    return n;
  endfunction

  // Digit-limit rule for one tap code (R6, R7).
  function automatic bit code_legal(input logic [CODE_W-1:0] code, input bit signed_digits);
    logic [TERM_W-1:0] a;
    logic [TERM_W-1:0] b;
    int v;
    for (int i = 0; i < SLOTS; i++) begin
      for (int j = i + 1; j < SLOTS; j++) begin
        a = slot_of(code, i);
        b = slot_of(code, j);
        if (a[EN_BIT] && b[EN_BIT] && (a[SHIFT_W-1:0] == b[SHIFT_W-1:0])) return 1'b0;
      end
    end
    v = code_value(code);
    if (signed_digits) begin
      if (code_digits(code) > SIGNED_MAX_DIGITS) return 1'b0;
    end else begin
      if (code_digits(code) > UNSIGNED_MAX_DIGITS) return 1'b0;
      for (int j = 0; j < SLOTS; j++) begin
        a = slot_of(code, j);
        if (a[EN_BIT] && a[NEG_BIT]) return 1'b0;
      end
    end
    if (v < 0 || v >= (1 << COEF_BITS)) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/shiftadd_fir_delay.sv
module shiftadd_fir_delay #(
  parameter int NTAPS = 8,
  parameter int IN_W  = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift_en,
  input  logic [IN_W-1:0]        din,
  output logic [NTAPS*IN_W-1:0]  taps_flat
);

  logic [IN_W-1:0] stage [NTAPS];

  // Advances only on an accepted sample (R2); reset wins (R1).
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAPS; k++) stage[k] <= '0;
    end else if (shift_en) begin
      stage[0] <= din;
      for (int k = 1; k < NTAPS; k++) stage[k] <= stage[k-1];
    end
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_out
    assign taps_flat[k*IN_W +: IN_W] = stage[k];
  end

endmodule

// File: rtl/shiftadd_fir_tap.sv
module shiftadd_fir_tap
  import shiftadd_fir_pkg::*;
#(
  parameter int               IN_W   = 12,
  parameter int               PROD_W = 23,
  parameter logic [CODE_W-1:0] CODE  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   sample,
  output logic [PROD_W-1:0] product
);

  logic signed [PROD_W-1:0] wide;
  assign wide = {{(PROD_W-IN_W){sample[IN_W-1]}}, sample};

  // One add, subtract or pass-through per slot, picked by the code (R5).
  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    localparam logic [TERM_W-1:0] TERM = CODE[j*TERM_W +: TERM_W];
    localparam int SH = int'(TERM[SHIFT_W-1:0]);
    logic signed [PROD_W-1:0] acc_in;
    logic signed [PROD_W-1:0] acc_out;
    if (j == 0) begin : g_first
      assign acc_in = '0;
    end else begin : g_chain
      assign acc_in = g_slot[j-1].acc_out;
    end
    if (!TERM[EN_BIT]) begin : g_skip
      assign acc_out = acc_in;
    end else if (TERM[NEG_BIT]) begin : g_sub
      assign acc_out = acc_in - (wide <<< SH);
    end else begin : g_add
      assign acc_out = acc_in + (wide <<< SH);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) product <= '0;
    else     product <= g_slot[SLOTS-1].acc_out;
  end

endmodule

// File: rtl/shiftadd_fir_tree.sv
module shiftadd_fir_tree
  import shiftadd_fir_pkg::*;
#(
  parameter int NLEAF = 8,
  parameter int W     = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLEAF*W-1:0] leaves,
  output logic [W-1:0]      sum
);

  localparam int LEVELS = tree_levels(NLEAF);
  localparam int WIDTH0 = 1 << LEVELS;

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int CNT = WIDTH0 >> l;
    logic [W-1:0] node [CNT];
    if (l == 0) begin : g_leaf
      // Missing leaves are zero when NLEAF is not a power of two (R9).
      always_comb begin
        for (int i = 0; i < CNT; i++) node[i] = '0;
        for (int i = 0; i < NLEAF; i++) node[i] = leaves[i*W +: W];
      end
    end else begin : g_add
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < CNT; i++) node[i] <= '0;
        end else begin
          for (int i = 0; i < CNT; i++)
            node[i] <= g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
        end
      end
    end
  end

  assign sum = g_lvl[LEVELS].node[0];

endmodule

// File: rtl/shiftadd_fir.sv
module shiftadd_fir
  import shiftadd_fir_pkg::*;
#(
  parameter int NTAPS         = 8,
  parameter int IN_W          = 12,
  parameter bit SIGNED_DIGITS = 1'b0,
  parameter logic [NTAPS*CODE_W-1:0] COEF_CODES = {
    {5'b00000, 5'b10001, 5'b10000},   // tap 7 = 3
    {5'b10011, 5'b10010, 5'b10001},   // tap 6 = 14
    {5'b00000, 5'b10101, 5'b10011},   // tap 5 = 40
    {5'b00000, 5'b10110, 5'b10011},   // tap 4 = 72
    {5'b00000, 5'b10110, 5'b10011},   // tap 3 = 72
    {5'b00000, 5'b10101, 5'b10011},   // tap 2 = 40
    {5'b10011, 5'b10010, 5'b10001},   // tap 1 = 14
    {5'b00000, 5'b10001, 5'b10000}    // tap 0 = 3
  },
  localparam int LEVELS  = tree_levels(NTAPS),
  localparam int OUT_W   = IN_W + COEF_BITS + LEVELS,
  localparam int LATENCY = 2 + LEVELS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  // Elaboration-time digit-limit check (R8).
  for (genvar k = 0; k < NTAPS; k++) begin : g_rule
    if (!code_legal(COEF_CODES[k*CODE_W +: CODE_W], SIGNED_DIGITS)) begin : g_bad
      $error("shiftadd_fir: tap %0d code breaks the digit limit of the selected mode", k);
    end
  end

  // Named internal buses, observed by the bound checker.
  logic [NTAPS*IN_W-1:0]  dl_flat;
  logic [NTAPS*OUT_W-1:0] prod_flat;
  logic [LATENCY-1:0]     vld_pipe;

  shiftadd_fir_delay #(
    .NTAPS (NTAPS),
    .IN_W  (IN_W)
  ) u_delay (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (in_valid),
    .din       (in_data),
    .taps_flat (dl_flat)
  );

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    shiftadd_fir_tap #(
      .IN_W   (IN_W),
      .PROD_W (OUT_W),
      .CODE   (COEF_CODES[k*CODE_W +: CODE_W])
    ) u_tap (
      .clk     (clk),
      .rst     (rst),
      .sample  (dl_flat[k*IN_W +: IN_W]),
      .product (prod_flat[k*OUT_W +: OUT_W])
    );
  end

  shiftadd_fir_tree #(
    .NLEAF (NTAPS),
    .W     (OUT_W)
  ) u_tree (
    .clk    (clk),
    .rst    (rst),
    .leaves (prod_flat),
    .sum    (out_data)
  );

  // Strobe follows the data: delay line, product, then one stage per level (R3).
  always_ff @(posedge clk) begin
    if (rst) vld_pipe <= '0;
    else     vld_pipe <= {vld_pipe[LATENCY-2:0], in_valid};
  end

  assign out_valid = vld_pipe[LATENCY-1];

endmodule

// File: rtl/shiftadd_fir_checker.sv
module shiftadd_fir_checker
  import shiftadd_fir_pkg::*;
#(
  parameter int NTAPS = 8,
  parameter int IN_W  = 12,
  parameter int OUT_W = 23,
  parameter logic [NTAPS*CODE_W-1:0] COEF_CODES = '0
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [IN_W-1:0]        in_data,
  input logic                   out_valid,
  input logic [OUT_W-1:0]       out_data,
  input logic [NTAPS*IN_W-1:0]  dl_flat,
  input logic [NTAPS*OUT_W-1:0] prod_flat
);

  localparam int LEVELS  = tree_levels(NTAPS);
  localparam int LATENCY = 2 + LEVELS;

  logic [LATENCY-1:0] accepted_hist;
  int                 settle;

  always_ff @(posedge clk) begin
    if (rst) accepted_hist <= '0;
    else     accepted_hist <= {accepted_hist[LATENCY-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    if (rst)                  settle <= 0;
    else if (settle <= LEVELS) settle <= settle + 1;
  end

  function automatic longint sum_products(input logic [NTAPS*OUT_W-1:0] p);
    longint s;
    s = 0;
    for (int k = 0; k < NTAPS; k++) s += longint'($signed(p[k*OUT_W +: OUT_W]));
    return s;
  endfunction

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0)); // R1

  AST_IDLE_HOLDS_LINE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(dl_flat)); // R2

  AST_NEWEST_TAP: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> dl_flat[IN_W-1:0] == $past(in_data)); // R2

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == accepted_hist[LATENCY-1]); // R3

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    localparam int COEF_K = code_value(COEF_CODES[k*CODE_W +: CODE_W]);
    AST_TAP_PRODUCT: assert property (@(posedge clk) disable iff (rst)
      !rst |=> longint'($signed(prod_flat[k*OUT_W +: OUT_W])) ==
               $past(longint'($signed(dl_flat[k*IN_W +: IN_W])) * longint'(COEF_K))); // R4
  end

  if (LEVELS > 0) begin : g_tree
    AST_TREE_SUM: assert property (@(posedge clk) disable iff (rst)
      (settle > LEVELS) |-> longint'($signed(out_data)) ==
                            $past(sum_products(prod_flat), LEVELS)); // R4
  end

endmodule

bind shiftadd_fir shiftadd_fir_checker #(
  .NTAPS      (NTAPS),
  .IN_W       (IN_W),
  .OUT_W      (OUT_W),
  .COEF_CODES (COEF_CODES)
) u_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .dl_flat   (dl_flat),
  .prod_flat (prod_flat)
);

// File: tb/test_shiftadd_fir.sv
module test_shiftadd_fir;
  import shiftadd_fir_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W  = 12;
  localparam int NT_U  = 8;
  localparam int NT_S  = 5;
  localparam int OUT_W = IN_W + 8 + 3;   // ceil(log2) is 3 for both 8 and 5 taps

  function automatic int ceil_lg(input int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    return r;
  endfunction

  localparam int LAT_U = 2 + ceil_lg(NT_U);
  localparam int LAT_S = 2 + ceil_lg(NT_S);

  function automatic logic [4:0] pterm(input int s);
    return {2'b10, 3'(s)};
  endfunction
  function automatic logic [4:0] nterm(input int s);
    return {2'b11, 3'(s)};
  endfunction
  localparam logic [4:0] NOTERM = 5'b00000;

  // Unsigned instance: 1,5,13,224,17,14,2,0 from tap 0 upwards.
  localparam logic [NT_U*15-1:0] CODES_U = {
    {NOTERM,   NOTERM,   NOTERM},
    {NOTERM,   NOTERM,   pterm(1)},
    {pterm(3), pterm(2), pterm(1)},
    {NOTERM,   pterm(4), pterm(0)},
    {pterm(7), pterm(6), pterm(5)},
    {pterm(3), pterm(2), pterm(0)},
    {NOTERM,   pterm(2), pterm(0)},
    {NOTERM,   NOTERM,   pterm(0)}
  };
  // Signed-digit instance: 7,9,24,56,127 from tap 0 upwards.
  localparam logic [NT_S*15-1:0] CODES_S = {
    {NOTERM, pterm(7), nterm(0)},
    {NOTERM, pterm(6), nterm(3)},
    {NOTERM, pterm(4), pterm(3)},
    {NOTERM, pterm(3), pterm(0)},
    {NOTERM, pterm(3), nterm(0)}
  };

  int coef_u [NT_U] = '{1, 5, 13, 224, 17, 14, 2, 0};
  int coef_s [NT_S] = '{7, 9, 24, 56, 127};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic out_valid_u, out_valid_s;
  logic [OUT_W-1:0] out_data_u, out_data_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  shiftadd_fir #(
    .NTAPS(NT_U), .IN_W(IN_W), .SIGNED_DIGITS(1'b0), .COEF_CODES(CODES_U)
  ) i_shiftadd_fir (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid_u), .out_data(out_data_u)
  );

  shiftadd_fir #(
    .NTAPS(NT_S), .IN_W(IN_W), .SIGNED_DIGITS(1'b1), .COEF_CODES(CODES_S)
  ) i_shiftadd_fir_sd (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid_s), .out_data(out_data_s)
  );

  typedef struct { int due; longint val; } exp_t;
  exp_t   expq [2][$];
  longint hist_u [NT_U];
  longint hist_s [NT_S];
  int     edge_n = 0;
  int     checks = 0;
  int     errors = 0;
  bit     prev_rst = 1'b1;
  bit     done = 1'b0;

  always @(posedge clk) edge_n <= edge_n + 1;

  task automatic check_one(input int idx, input logic ov, input longint od, input string tag);
    bit ev;
    ev = (expq[idx].size() > 0) && (expq[idx][0].due == edge_n);
    checks++;
    if (ov !== ev) begin
      errors++;
      $display("FAIL R3 dut%0d edge %0d out_valid actual %0b expected %0b", idx, edge_n, ov, ev);
    end
    if (ev) begin
      checks++;
      if (od != expq[idx][0].val) begin
        errors++;
        $display("FAIL %s dut%0d edge %0d out_data actual %0d expected %0d",
                 tag, idx, edge_n, od, expq[idx][0].val);
      end
      void'(expq[idx].pop_front());
    end
  endtask

  task automatic compare_outputs();
    check_one(0, out_valid_u, longint'($signed(out_data_u)), "R4 R6");
    check_one(1, out_valid_s, longint'($signed(out_data_s)), "R4 R7 R9");
    if (prev_rst) begin
      checks++;
      if (out_valid_u !== 1'b0 || out_data_u !== '0 || out_valid_s !== 1'b0 || out_data_s !== '0) begin
        errors++;
        $display("FAIL R1 after reset edge: valid %0b/%0b data %0d/%0d expected 0/0 data 0/0",
                 out_valid_u, out_valid_s, out_data_u, out_data_s);
      end
    end
  endtask

  task automatic step(input bit r, input bit v, input logic [IN_W-1:0] d);
    longint acc;
    compare_outputs();
    rst = r;
    in_valid = v;
    in_data = d;
    if (r) begin
      for (int k = 0; k < NT_U; k++) hist_u[k] = 0;
      for (int k = 0; k < NT_S; k++) hist_s[k] = 0;
      expq[0].delete();
      expq[1].delete();
    end else if (v) begin
      for (int k = NT_U - 1; k > 0; k--) hist_u[k] = hist_u[k-1];
      for (int k = NT_S - 1; k > 0; k--) hist_s[k] = hist_s[k-1];
      hist_u[0] = longint'($signed(d));
      hist_s[0] = longint'($signed(d));
      acc = 0;
      for (int k = 0; k < NT_U; k++) acc += hist_u[k] * coef_u[k];
      expq[0].push_back('{edge_n + LAT_U, acc});
      acc = 0;
      for (int k = 0; k < NT_S; k++) acc += hist_s[k] * coef_s[k];
      expq[1].push_back('{edge_n + LAT_S, acc});
    end
    prev_rst = r;
    @(negedge clk);
  endtask

  task automatic check_bit(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset, with a sample offered during reset that must not be accepted
    step(1, 0, '0);
    step(1, 1, 12'sd1234);
    step(1, 1, 12'sd777);
    for (int i = 0; i < 8; i++) step(0, 1, '0);

    // R4: unit impulse reads out the coefficients
    step(0, 1, 12'sd1);
    for (int i = 0; i < 10; i++) step(0, 1, '0);
    // R4: most negative impulse
    step(0, 1, 12'h800);
    for (int i = 0; i < 10; i++) step(0, 1, '0);

    // R2: idle gaps carrying random data
    step(0, 1, 12'sd100);
    for (int i = 0; i < 4; i++) step(0, 0, 12'($urandom));
    step(0, 1, 12'sd37);
    for (int i = 0; i < 3; i++) step(0, 0, 12'($urandom));
    for (int i = 0; i < 8; i++) step(0, 1, 12'($urandom));

    // R4: extreme magnitudes filling every tap
    for (int i = 0; i < 12; i++) step(0, 1, 12'h800);
    for (int i = 0; i < 12; i++) step(0, 1, 12'h7FF);
    for (int i = 0; i < 12; i++) step(0, 1, (i % 2) ? 12'h7FF : 12'h800);

    // Random stream with random gaps and a mid-stream reset (R1, R2)
    for (int i = 0; i < 400; i++) begin
      if (i == 200) step(1, 1, 12'($urandom));
      else step(0, ($urandom % 10) < 7, 12'($urandom));
    end

    // Drain; every accepted sample must have produced its pulse (R3)
    for (int i = 0; i < 12; i++) step(0, 0, 12'($urandom));
    checks++;
    if (expq[0].size() != 0 || expq[1].size() != 0) begin
      errors++;
      $display("FAIL R3 pending results actual %0d/%0d expected 0/0", expq[0].size(), expq[1].size());
    end

    // Code format and digit-limit rules (R5, R6, R7, R8)
    check_bit("R5 value 8-1",  code_value({NOTERM, pterm(3), nterm(0)}), 7);
    check_bit("R5 value 64-8", code_value({NOTERM, pterm(6), nterm(3)}), 56);
    check_bit("R5 value 224",  code_value({pterm(7), pterm(6), pterm(5)}), 224);
    check_bit("R6 224 legal unsigned", int'(code_legal({pterm(7), pterm(6), pterm(5)}, 1'b0)), 1);
    check_bit("R6 R8 negative term rejected unsigned", int'(code_legal({NOTERM, pterm(3), nterm(0)}, 1'b0)), 0);
    check_bit("R6 R8 repeated shift rejected", int'(code_legal({NOTERM, pterm(2), pterm(2)}, 1'b0)), 0);
    check_bit("R7 9=8+1 legal signed", int'(code_legal({NOTERM, pterm(3), pterm(0)}, 1'b1)), 1);
    check_bit("R7 R8 three digits rejected signed", int'(code_legal({pterm(3), pterm(2), pterm(0)}, 1'b1)), 0);
    check_bit("R7 R8 negative value rejected", int'(code_legal({NOTERM, nterm(4), pterm(0)}, 1'b1)), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog: run still active, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule